// File: doc/BRIEF.md
# Calibrated Fractional Seconds Prescaler

This block turns a slow oscillator tick (nominally 32.768 kHz, presented as a one-cycle enable in the system clock domain) into a one-cycle strobe once per second. The length of each second is set by a calibration word. Its integer field gives the number of oscillator ticks per second, less one. Its fractional field, when enabled, adds one extra tick to a chosen number of seconds in every sixteen. This trims the average rate in steps of 1/16 tick per second.

The stored word can be read back at any time. A new word changes nothing in the second already under way. It is taken up at the next second boundary, so each second is counted wholly with one setting. The block sits between an oscillator enable generator and a time-of-day counter, which consumes the strobe.

Top module: `cal_sec_prescaler`

## Requirements
- R1: After reset the stored word reads 0x07FFF (integer field 0x7FFF, fractional field 0, enable bit 0), the 16-second position is 0, and the first second lasts 32768 ticks.
- R2: A write with cal_we high stores all 21 bits of cal_wdata, and cal_rdata shows them from the next clock. The word never changes without a write.
- R3: With fractional compensation off (bit 20 = 0), every second lasts integer field (bits [15:0]) + 1 oscillator ticks.
- R4: With bit 20 = 1 and fractional field N (bits [19:16]), a second whose position in the 16-second cycle is below N lasts one extra tick. Positions run 0..15, starting at 0 for the first second after reset.
- R5: When bit 20 is 0, the fractional field has no effect on second lengths.
- R6: A written word governs second lengths only from the next second boundary. The second in progress ends with the old setting. A write in the very cycle of a boundary applies to the second that starts there.
- R7: sec_pulse is high for one clock cycle per second, and only in a cycle where osc_tick is high. Cycles with osc_tick low advance nothing.
- R8: The 16-second position advances by one at each second boundary and wraps from 15 to 0, so the fractional pattern repeats every 16 seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle oscillator tick enable |
| cal_we | input | 1 | Calibration write strobe |
| cal_wdata | input | 21 | Calibration word to store |
| cal_rdata | output | 21 | Stored calibration word |
| sec_pulse | output | 1 | One-cycle seconds strobe |

## Verification
The assertions take it that cal_we is held low during reset, and that osc_tick is a clean enable that is sampled on the rising clock edge. They accept any spacing of ticks, including back-to-back ticks. The stimulus changes every input only on the falling edge. It writes either between ticks or exactly on a boundary tick, and it runs one scenario with ticks spaced one in three cycles, so that idle cycles fall inside seconds.

// File: rtl/cal_sec_prescaler.sv
module cal_sec_prescaler #(
  parameter int INT_W = 16,
  parameter int FRAC_W = 4,
  parameter logic [INT_W+FRAC_W:0] CAL_RST = 'h7FFF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    osc_tick,
  input  logic                    cal_we,
  input  logic [INT_W+FRAC_W:0]   cal_wdata,
  output logic [INT_W+FRAC_W:0]   cal_rdata,
  output logic                    sec_pulse
);
  localparam int CAL_W = INT_W + FRAC_W + 1;
  localparam int CNT_W = INT_W + 1;

  logic [CAL_W-1:0]  cal_q, act_q, cal_next;
  logic [CNT_W-1:0]  cnt_q, last_cnt;
  logic [FRAC_W-1:0] cyc_q;
  logic [INT_W-1:0]  act_int;
  logic [FRAC_W-1:0] act_frac;
  logic              act_en, extra, at_end;

  assign act_int   = act_q[INT_W-1:0];
  assign act_frac  = act_q[INT_W +: FRAC_W];
  assign act_en    = act_q[CAL_W-1];
  assign extra     = act_en && (cyc_q < act_frac);
  assign last_cnt  = {1'b0, act_int} + CNT_W'(extra);
  assign at_end    = (cnt_q == last_cnt);
  assign sec_pulse = osc_tick && at_end;
  assign cal_next  = cal_we ? cal_wdata : cal_q;
  assign cal_rdata = cal_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_q <= CAL_RST;
      act_q <= CAL_RST;
      cnt_q <= '0;
      cyc_q <= '0;
    end else begin
      cal_q <= cal_next;
      if (osc_tick) begin
        if (at_end) begin
          cnt_q <= '0;
          cyc_q <= cyc_q + 1'b1;
          act_q <= cal_next;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cal_sec_prescaler_chk.sv
module cal_sec_prescaler_chk #(
  parameter int INT_W = 16,
  parameter int FRAC_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    osc_tick,
  input logic                    cal_we,
  input logic [INT_W+FRAC_W:0]   cal_wdata,
  input logic [INT_W+FRAC_W:0]   cal_rdata,
  input logic                    sec_pulse,
  input logic [INT_W+FRAC_W:0]   act_q,
  input logic [INT_W:0]          cnt_q,
  input logic [FRAC_W-1:0]       cyc_q
);
  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> osc_tick); // R7
  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    cal_we |=> cal_rdata == $past(cal_wdata)); // R2
  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_we |=> $stable(cal_rdata)); // R2
  AST_ACT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_pulse |=> $stable(act_q)); // R6
  AST_CYC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> cyc_q == FRAC_W'($past(cyc_q) + 1'b1)); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> $stable(cnt_q) && $stable(cyc_q)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= {1'b0, act_q[INT_W-1:0]} + 1'b1); // R3
endmodule

bind cal_sec_prescaler cal_sec_prescaler_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cal_we(cal_we),
  .cal_wdata(cal_wdata), .cal_rdata(cal_rdata), .sec_pulse(sec_pulse),
  .act_q(act_q), .cnt_q(cnt_q), .cyc_q(cyc_q)
);

// File: tb/cal_sec_prescaler_tb_top.sv
module cal_sec_prescaler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_tick = 1'b0;
  logic        cal_we = 1'b0;
  logic [20:0] cal_wdata = '0;
  logic [20:0] cal_rdata;
  logic        sec_pulse;

  int n_chk = 0, n_bad = 0, cycles = 0;
  int tick_cnt = 0, last_len = 0, sec_idx = 0;
  bit got = 0;

  always #2 clk = ~clk;

  cal_sec_prescaler dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cal_we(cal_we),
    .cal_wdata(cal_wdata), .cal_rdata(cal_rdata), .sec_pulse(sec_pulse)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(logic [20:0] w, int idx);
    return int'(w[15:0]) + 1 + ((w[20] && (idx % 16) < int'(w[19:16])) ? 1 : 0);
  endfunction

  task automatic cyc(logic t, logic we, logic [20:0] d);
    @(negedge clk);
    osc_tick = t; cal_we = we; cal_wdata = d;
    #1;
    got = 0;
    if (sec_pulse && !t) check("R7 pulse without tick", 1, 0);
    if (t) begin
      tick_cnt++;
      if (sec_pulse) begin
        last_len = tick_cnt; tick_cnt = 0; got = 1;
      end
    end
  endtask

  task automatic write_cal(logic [20:0] d);
    cyc(0, 1, d);
    cyc(0, 0, '0);
    check("R2 readback", int'(cal_rdata), int'(d));
  endtask

  task automatic run_sec(int exp, string req, int gap);
    do begin
      for (int g = 0; g < gap; g++) cyc(0, 0, '0);
      cyc(1, 0, '0);
    end while (!got);
    cyc(0, 0, '0);
    if (sec_pulse) check("R7 pulse width", 1, 0);
    check(req, last_len, exp);
    sec_idx++;
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset word", int'(cal_rdata), 'h07FFF);
    check("R1 no pulse at reset", int'(sec_pulse), 0);
  endtask

  task automatic t_first_second;
    write_cal(21'h00003);
    run_sec(32768, "R1 R6 first second uses reset word", 0);
    for (int i = 0; i < 3; i++) run_sec(4, "R3 integer period", 0);
  endtask

  task automatic t_late_write;
    write_cal(21'h00006);
    run_sec(4, "R6 second in progress keeps old", 0);
    run_sec(7, "R6 new word next second", 0);
  endtask

  task automatic t_frac_disabled;
    write_cal(21'h0F0003);
    run_sec(7, "R6 old word", 0);
    run_sec(4, "R5 fraction ignored", 0);
    run_sec(4, "R5 fraction ignored", 0);
  endtask

  task automatic t_boundary_write;
    for (int i = 0; i < 3; i++) cyc(1, 0, '0);
    cyc(1, 1, 21'h00001);
    check("R6 boundary pulse", int'(got), 1);
    check("R6 boundary second length", last_len, 4);
    sec_idx++;
    cyc(0, 0, '0);
    run_sec(2, "R6 boundary write applies at once", 0);
  endtask

  task automatic t_fraction;
    logic [20:0] w;
    w = 21'h150002;
    write_cal(w);
    run_sec(2, "R6 old word before fraction", 0);
    for (int i = 0; i < 32; i++)
      run_sec(exp_len(w, sec_idx), "R4 R8 fractional spreading", 0);
  endtask

  task automatic t_sparse_ticks;
    logic [20:0] w;
    w = 21'h00004;
    write_cal(w);
    run_sec(exp_len(21'h150002, sec_idx), "R4 old fractional word", 0);
    for (int i = 0; i < 3; i++) run_sec(5, "R7 idle cycles not counted", 2);
    write_cal(21'h1A5A5A);
  endtask

  initial begin
    t_reset();
    t_first_second();
    t_late_write();
    t_frac_disabled();
    t_boundary_write();
    t_fraction();
    t_sparse_ticks();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule